// File: doc/BRIEF.md
# Ling Pseudo-Carry Lookahead Adder

This block adds two unsigned N-bit operands and a carry-in, and produces an N-bit sum and a carry-out. It does not pass true carries from bit to bit. It passes a pseudo-carry instead. The pseudo-carry entering a bit is the OR of that bit's carry-in and the carry-in of the bit below it.

The work happens in three combinational stages:

1. Every bit forms its generate (a AND b), propagate (a XOR b) and transmit (a OR b) terms.
2. The pseudo-carry chain is resolved. Inside each 4-bit group this is done with serial lookahead. Across groups it uses a logarithmic parallel-prefix tree.
3. Each true carry is rebuilt by ANDing the pseudo-carry with the transmit term of the bit below. That carry is then XORed with propagate to give the sum bit.

The carry-in acts as the pseudo-carry at position zero, and the transmit term below bit zero is taken as 1. A parameter adds an output register for timing closure. The register has an asynchronous active-low reset.

Top module: `ling_adder`

## Requirements
- R1: The sum output equals the low WIDTH bits of the arithmetic total of operand A, operand B and the carry-in.
- R2: The carry-out equals bit WIDTH of that arithmetic total, so it is 1 exactly when the total reaches 2^WIDTH.
- R3: With the output register enabled, both outputs show the result for the inputs present at the previous rising clock edge. They hold that value until the next edge, and a new operand pair is accepted on every cycle.
- R4: While the active-low reset is low, the registered sum and carry-out are 0. Asserting the reset clears them at once, without waiting for a clock edge.
- R5: All-ones plus zero with carry-in 1 gives sum 0 and carry-out 1. All-ones plus all-ones with carry-in 1 gives sum all-ones and carry-out 1.
- R6: Zero plus zero gives sum 0 and carry-out 0 when the carry-in is 0. With carry-in 1 it gives sum 1 and carry-out 0.
- R7: A carry travels across every bit position and every 4-bit group boundary. For each k from 1 to WIDTH, adding 2^k-1 and 1 gives 2^k, and at k = WIDTH this is sum 0 with carry-out 1. Internally, the pseudo-carry above each bit equals the OR of that bit's true carry-out and true carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B |
| cin_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Sum, low WIDTH bits of the total |
| cout_o | output | 1 | Carry-out |

## Verification
The operand patterns are chosen so that each one exercises a different part of the carry network:

- All-ones plus a carry-in pushes one carry through every group and through the top-level prefix tree.
- Zero operands show whether a stray generate or transmit term is leaking.
- Alternating operands (0xAAAA.. and 0x5555..) make every bit a propagate bit. Adding an alternating pattern to itself turns every other bit into a generate bit. Together these separate the propagate, generate and transmit paths.
- A sweep of 2^k-1 plus 1 ends a carry run at every bit position. This exposes a wrong group boundary or a wrong prefix distance.
- Ten thousand random pairs cover mixed carry runs, and one-cycle tests of register hold and asynchronous clear confirm the timing.

// File: rtl/ling_pkg.sv
package ling_pkg;

    // Generate/propagate pair for the pseudo-carry recurrence
    // h[i+1] = gen[i] | (prop[i] & h[i]), where prop[i] is the transmit term of bit i-1.
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

    // Fold a lower span into an upper span of the recurrence.
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.gen  = hi.gen | (hi.prop & lo.gen);
        r.prop = hi.prop & lo.prop;
        return r;
    endfunction

endpackage

// File: rtl/ling_bitgen.sv
// Stage one: per-bit generate, propagate and transmit terms.
module ling_bitgen #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prp_o,
    output logic [WIDTH-1:0] trn_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            gen_o[i] = opa_i[i] & opb_i[i];
            prp_o[i] = opa_i[i] ^ opb_i[i];
            trn_o[i] = gen_o[i] | prp_o[i];
        end
    end

endmodule

// File: rtl/ling_hchain.sv
// Stage two: pseudo-carry chain. Serial lookahead inside each group,
// parallel-prefix tree across groups. psc_o[0] is the carry-in,
// psc_o[i+1] is the pseudo-carry above bit i.
module ling_hchain
    import ling_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH-1:0] trn_i,
    input  logic             cin_i,
    output logic [WIDTH:0]   psc_o
);

    localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;
    localparam int PADW = NGRP * GROUP;
    localparam int LVLS = (NGRP > 1) ? $clog2(NGRP) : 1;

    logic [PADW-1:0] gen_pad;
    logic [PADW-1:0] trn_pad;
    gp_t             bit_gp   [PADW];
    gp_t             loc_gp   [NGRP][GROUP];
    gp_t             tree_gp  [LVLS+1][NGRP];
    logic            grp_hin  [NGRP];
    logic [PADW:0]   psc_full;

    // Pad the high end with zeros so every group is full width.
    always_comb begin
        gen_pad = '0;
        trn_pad = '0;
        gen_pad[WIDTH-1:0] = gen_i;
        trn_pad[WIDTH-1:0] = trn_i;
    end

    // Bit-level pair: transmit below bit 0 is taken as 1.
    for (genvar i = 0; i < PADW; i++) begin : g_bitgp
        if (i == 0) begin : g_lsb
            always_comb begin
                bit_gp[i].gen  = gen_pad[i];
                bit_gp[i].prop = 1'b1;
            end
        end else begin : g_rest
            always_comb begin
                bit_gp[i].gen  = gen_pad[i];
                bit_gp[i].prop = trn_pad[i-1];
            end
        end
    end

    // Serial lookahead inside each group.
    for (genvar j = 0; j < NGRP; j++) begin : g_grp
        for (genvar k = 0; k < GROUP; k++) begin : g_pos
            if (k == 0) begin : g_first
                always_comb loc_gp[j][k] = bit_gp[j*GROUP];
            end else begin : g_next
                always_comb loc_gp[j][k] = gp_merge(bit_gp[j*GROUP+k], loc_gp[j][k-1]);
            end
        end
        always_comb tree_gp[0][j] = loc_gp[j][GROUP-1];
    end

    // Parallel-prefix tree over group totals.
    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        for (genvar j = 0; j < NGRP; j++) begin : g_node
            if (j >= (1 << l)) begin : g_comb
                always_comb tree_gp[l+1][j] = gp_merge(tree_gp[l][j], tree_gp[l][j-(1<<l)]);
            end else begin : g_pass
                always_comb tree_gp[l+1][j] = tree_gp[l][j];
            end
        end
    end

    // Pseudo-carry entering each group, then the per-bit values.
    for (genvar j = 0; j < NGRP; j++) begin : g_hin
        if (j == 0) begin : g_base
            always_comb grp_hin[j] = cin_i;
        end else begin : g_upper
            always_comb grp_hin[j] = tree_gp[LVLS][j-1].gen
                                   | (tree_gp[LVLS][j-1].prop & cin_i);
        end
        for (genvar k = 0; k < GROUP; k++) begin : g_out
            always_comb psc_full[j*GROUP+k+1] = loc_gp[j][k].gen
                                              | (loc_gp[j][k].prop & grp_hin[j]);
        end
    end

    always_comb psc_full[0] = cin_i;
    always_comb psc_o = psc_full[WIDTH:0];

    logic unused_pad;
    always_comb unused_pad = ^psc_full;

endmodule

// File: rtl/ling_sumgen.sv
// Stage three: rebuild true carries from the pseudo-carries and form the sum.
module ling_sumgen #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] prp_i,
    input  logic [WIDTH-1:0] trn_i,
    input  logic [WIDTH:0]   psc_i,
    output logic [WIDTH-1:0] cry_o,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            always_comb cry_o[i] = psc_i[0];
        end else begin : g_rest
            always_comb cry_o[i] = trn_i[i-1] & psc_i[i];
        end
        always_comb sum_o[i] = prp_i[i] ^ cry_o[i];
    end

    always_comb cout_o = psc_i[WIDTH] & trn_i[WIDTH-1];

endmodule

// File: rtl/ling_adder.sv
module ling_adder #(
    parameter int WIDTH   = 32,
    parameter int GROUP   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    typedef struct packed {
        logic             cout;
        logic [WIDTH-1:0] sum;
    } res_t;

    logic [WIDTH-1:0] gen_w;
    logic [WIDTH-1:0] prp_w;
    logic [WIDTH-1:0] trn_w;
    logic [WIDTH:0]   psc_w;
    logic [WIDTH-1:0] cry_w;
    logic [WIDTH-1:0] sum_w;
    logic             cout_w;
    res_t             res_d;
    res_t             res_q;

    ling_bitgen #(.WIDTH(WIDTH)) u_bitgen (
        .opa_i (opa_i),
        .opb_i (opb_i),
        .gen_o (gen_w),
        .prp_o (prp_w),
        .trn_o (trn_w)
    );

    ling_hchain #(.WIDTH(WIDTH), .GROUP(GROUP)) u_hchain (
        .gen_i (gen_w),
        .trn_i (trn_w),
        .cin_i (cin_i),
        .psc_o (psc_w)
    );

    ling_sumgen #(.WIDTH(WIDTH)) u_sumgen (
        .prp_i  (prp_w),
        .trn_i  (trn_w),
        .psc_i  (psc_w),
        .cry_o  (cry_w),
        .sum_o  (sum_w),
        .cout_o (cout_w)
    );

    always_comb begin
        res_d      = '0;
        res_d.sum  = sum_w;
        res_d.cout = cout_w;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        always_comb res_q = res_d;
    end

    always_comb begin
        sum_o  = res_q.sum;
        cout_o = res_q.cout;
    end

    // ---------------- assertions ----------------
    logic [WIDTH:0] arith_w;
    logic [WIDTH:0] rip_c;

    always_comb begin
        arith_w = {1'b0, opa_i} + {1'b0, opb_i} + {{WIDTH{1'b0}}, cin_i};
        rip_c[0] = cin_i;
        for (int i = 0; i < WIDTH; i++) begin
            rip_c[i+1] = (opa_i[i] & opb_i[i]) | ((opa_i[i] | opb_i[i]) & rip_c[i]);
        end
    end

    a_r1_sum_low: assert property (@(posedge clk) disable iff (!rst_n)
        res_d.sum == arith_w[WIDTH-1:0]);

    a_r2_cout_top: assert property (@(posedge clk) disable iff (!rst_n)
        res_d.cout == arith_w[WIDTH]);

    a_r5_wrap_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ((&opa_i) && (opb_i == '0) && cin_i) |-> (res_d.sum == '0 && res_d.cout));

    a_r7_pseudo_def: assert property (@(posedge clk) disable iff (!rst_n)
        psc_w[WIDTH:1] == (rip_c[WIDTH:1] | rip_c[WIDTH-1:0]));

    a_r7_carry_recover: assert property (@(posedge clk) disable iff (!rst_n)
        cry_w == rip_c[WIDTH-1:0]);

    if (REG_OUT) begin : g_reg_chk
        a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> ({cout_o, sum_o} == $past(arith_w)));
    end

endmodule

// File: tb/ling_adder_tb_top.sv
module ling_adder_tb_top;

    localparam int W    = 32;
    localparam int NVEC = 10;
    localparam int NRND = 10000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int n_chk  = 0;
    int n_err  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ling_adder #(.WIDTH(W), .GROUP(4), .REG_OUT(1'b1)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .opa_i  (opa),
        .opb_i  (opb),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    // {a, b, cin}
    localparam logic [2*W:0] VEC [NVEC] = '{
        {32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
        {32'h0000_0000, 32'h0000_0000, 1'b0},
        {32'h0000_0000, 32'h0000_0000, 1'b1},
        {32'hAAAA_AAAA, 32'h5555_5555, 1'b0},
        {32'hAAAA_AAAA, 32'h5555_5555, 1'b1},
        {32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
        {32'h8000_0000, 32'h8000_0000, 1'b0},
        {32'h7FFF_FFFF, 32'h0000_0001, 1'b0},
        {32'h1234_5678, 32'h0FED_CBA9, 1'b0}
    };

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    endfunction

    // Drive at a falling edge, sample at the next falling edge (one rising edge between).
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        @(negedge clk);
        opa = a;
        opb = b;
        cin = c;
        @(negedge clk);
    endtask

    initial begin
        logic [W:0] exp;
        logic [W:0] prev;
        // R4: outputs at 0 during reset, even with active inputs
        opa = 32'hFFFF_FFFF;
        opb = 32'h1;
        repeat (3) @(negedge clk);
        check("R4", {cout, sum}, '0);
        rst_n = 1'b1;

        // Table walk: R1 sum, R2 carry-out
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][2*W:W+1], VEC[v][W:1], VEC[v][0]);
            exp = model(VEC[v][2*W:W+1], VEC[v][W:1], VEC[v][0]);
            check("R1", {1'b0, sum}, {1'b0, exp[W-1:0]});
            check("R2", {{W{1'b0}}, cout}, {{W{1'b0}}, exp[W]});
        end

        // R5: all-ones corners
        apply(32'hFFFF_FFFF, 32'h0, 1'b1);
        check("R5", {cout, sum}, {1'b1, 32'h0});
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        check("R5", {cout, sum}, {1'b1, 32'hFFFF_FFFF});

        // R6: zero operands
        apply(32'h0, 32'h0, 1'b0);
        check("R6", {cout, sum}, {1'b0, 32'h0});
        apply(32'h0, 32'h0, 1'b1);
        check("R6", {cout, sum}, {1'b0, 32'h1});

        // R7: carry run ending at each position k
        for (int k = 1; k <= W; k++) begin
            apply(W'((64'd1 << k) - 64'd1), 32'h1, 1'b0);
            exp = (W+1)'(64'd1 << k);
            check("R7", {cout, sum}, exp);
        end

        // R3: output holds until the next rising edge, then follows
        apply(32'h0000_00FF, 32'h0000_0001, 1'b0);
        prev = {1'b0, 32'h0000_0100};
        @(negedge clk);
        opa = 32'h0F0F_0F0F;
        opb = 32'hF0F0_F0F1;
        cin = 1'b0;
        #1;
        check("R3", {cout, sum}, prev);
        @(negedge clk);
        check("R3", {cout, sum}, {1'b1, 32'h0});
        // back-to-back vectors, one per cycle
        @(negedge clk);
        opa = 32'h1;
        opb = 32'h2;
        cin = 1'b1;
        @(negedge clk);
        check("R3", {cout, sum}, {1'b0, 32'h4});
        opa = 32'h8000_0000;
        opb = 32'h8000_0001;
        cin = 1'b0;
        @(negedge clk);
        check("R3", {cout, sum}, {1'b1, 32'h1});

        // Random vectors: R1 and R2
        for (int r = 0; r < NRND; r++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            logic         rc;
            ra = $urandom;
            rb = $urandom;
            rc = 1'($urandom);
            apply(ra, rb, rc);
            exp = model(ra, rb, rc);
            check("R1 R2", {cout, sum}, exp);
        end

        // R4: asynchronous clear without a clock edge
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        check("R4", {cout, sum}, {1'b1, 32'hFFFF_FFFE});
        #2;
        rst_n = 1'b0;
        #1;
        check("R4", {cout, sum}, '0);
        @(negedge clk);
        check("R4", {cout, sum}, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule